// File: doc/BRIEF.md
# Shadow Region Attribute Decoder

This block sets access rules for the legacy memory window from 0C0000h to 0FFFFFh. It holds seven byte-wide attribute registers at byte offsets 59h through 5Fh. Each nibble of these registers holds the attribute for one memory region. The field for a region has three bits: a read enable, a write enable and a cache enable.

For every processor access, the block decides two things:
- whether the access is served by main DRAM or is forwarded to the expansion bus;
- whether the access may be cached.

For every PCI master access, it decides whether the cycle is claimed.

A region can be made write-only while its reads still go to the expansion bus. This lets firmware copy an expansion ROM into DRAM at the same address, and then switch the region to read-only. An access outside the window does not use the attribute registers: it goes to DRAM and is cacheable. A memory-hole enable input stops PCI masters from claiming a fixed hole range.

The access ports carry a one-cycle strobe and have no back-pressure. The decoder accepts an access in every cycle. Each result is registered and shows up together with a done pulse one cycle later. The configuration port is a plain register write/read port. Its write takes effect at the clock edge. Its read data is combinational.

Top module: `shadow_region_decoder`

## Requirements
- R1: After reset, every attribute register reads 0. Every access inside the window is therefore forwarded, is not cacheable and is not claimed by PCI.
- R2: The attribute field layout is: bit 0 read enable, bit 1 write enable, bit 2 cache enable, bit 3 reserved. The high nibble repeats this layout in bits 4 to 7. The high nibble of offset 59h covers 0F0000h–0FFFFFh. Offsets 5Ah–5Fh cover the twelve 16 KB regions from 0C0000h to 0EFFFFh in rising order, low nibble first.
- R3: Bits 3 and 7 of every attribute register, and bits 3:0 of offset 59h, read back 0 and ignore writes. Offsets outside 59h–5Fh read 0 and ignore writes.
- R4: When read enable and write enable are both 0, reads and writes to the region are forwarded to the expansion bus and are not cacheable.
- R5: When only read enable is set:
  - reads go to DRAM and writes are forwarded;
  - an access is cacheable only if it is a code-fetch read and cache enable is set.
- R6: When only write enable is set, writes go to DRAM, reads are forwarded, and no access is cacheable.
- R7: When read enable and write enable are both set, reads and writes go to DRAM. They are cacheable exactly when cache enable is set.
- R8: A PCI master write is claimed only if its region is writeable. A PCI master read is claimed only if its region is readable.
- R9: While hole_en is 1, a PCI master access inside HOLE_BASE..HOLE_LAST (default 0F00000h–0FFFFFFh) is never claimed.
- R10: An access outside 0C0000h–0FFFFFh goes to DRAM and is cacheable. A PCI access there is claimed unless R9 applies.
- R11: Each result and its done pulse appear in the cycle after the access strobe, and are 0 in any cycle without a done pulse. An access in the same cycle as a configuration write sees the attributes from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| host_valid | input | 1 | Processor access strobe |
| host_addr | input | ADDR_W | Processor access address |
| host_write | input | 1 | 1 = write, 0 = read |
| host_code | input | 1 | Code-fetch read |
| host_done | output | 1 | Processor result valid |
| host_to_dram | output | 1 | 1 = served by DRAM, 0 = forwarded to expansion bus |
| host_cacheable | output | 1 | Access may be cached |
| pci_valid | input | 1 | PCI master access strobe |
| pci_addr | input | ADDR_W | PCI master address |
| pci_write | input | 1 | 1 = write, 0 = read |
| hole_en | input | 1 | Memory hole enabled |
| pci_done | output | 1 | PCI result valid |
| pci_claim | output | 1 | Claim the PCI cycle (device select) |

## Verification
- **Access results.** Every access result is due exactly one clock after its strobe. The bench drives each strobe on a falling edge and compares the outputs on the next falling edge. By then the single register stage has loaded, and the strobe is removed in the same step.
- **Configuration reads.** Read data is combinational. The bench checks it a short delay after the offset is driven, with no clock edge in between.
- **Same-cycle write.** For an access issued in the same cycle as a configuration write, the expected value comes from the model state before that write. The model is updated only afterwards.

// File: rtl/shadow_attr_pkg.sv
`timescale 1ns/1ps
package shadow_attr_pkg;

  typedef struct packed {
    logic cache_en;
    logic wr_en;
    logic rd_en;
  } attr_t;

  localparam int unsigned NIB_W = 4;

  function automatic attr_t nib_to_attr(input logic [NIB_W-1:0] nib);
    attr_t a;
    a.rd_en    = nib[0];
    a.wr_en    = nib[1];
    a.cache_en = nib[2];
    return a;
  endfunction

  // DRAM or expansion bus; outside the window always DRAM
  function automatic logic route_dram(input logic in_win, input attr_t a,
                                      input logic wr);
    if (!in_win) return 1'b1;
    return wr ? a.wr_en : a.rd_en;
  endfunction

  // cacheable only for readable regions: read/write regions fully,
  // read-only regions just for code-fetch reads
  function automatic logic route_cache(input logic in_win, input attr_t a,
                                       input logic wr, input logic code);
    if (!in_win) return 1'b1;
    return a.rd_en & a.cache_en & (wr ? a.wr_en : (a.wr_en | code));
  endfunction

endpackage

// File: rtl/shadow_attr_regs.sv
`timescale 1ns/1ps
module shadow_attr_regs #(
  parameter int unsigned NUM_REGS = 7,
  parameter logic [7:0]  BASE_OFF = 8'h59
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  output logic [NUM_REGS*8-1:0] attr_bits
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    // first register keeps its low nibble reserved
    localparam logic [7:0] MASK = (g == 0) ? 8'h70 : 8'h77;
    localparam logic [7:0] OFF  = BASE_OFF + 8'(g);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        q <= '0;
      else if (cfg_we && cfg_addr == OFF) q <= cfg_wdata & MASK;
    end
    assign attr_bits[g*8 +: 8] = q;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cfg_addr == BASE_OFF + 8'(i)) cfg_rdata = attr_bits[i*8 +: 8];
    end
  end

endmodule

// File: rtl/shadow_region_map.sv
`timescale 1ns/1ps
module shadow_region_map #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [ADDR_W-1:14] seg_addr,
  output logic               in_window,
  output logic [IDX_W-1:0]   nib_idx
);
  // window 0C0000h..0FFFFFh; 0F0000h.. is one 64 KB region (nibble 1),
  // the rest are 16 KB regions starting at nibble 2
  localparam int unsigned WIN_LSB = 18;
  localparam int unsigned SEG_LSB = 14;

  assign in_window = (seg_addr[ADDR_W-1:20] == '0) &&
                     (seg_addr[19:WIN_LSB] == 2'b11);

  always_comb begin
    if (seg_addr[17:16] == 2'b11) nib_idx = IDX_W'(1);
    else nib_idx = IDX_W'(2) + IDX_W'(seg_addr[17:SEG_LSB]);
  end

endmodule

// File: rtl/shadow_region_decoder.sv
`timescale 1ns/1ps
module shadow_region_decoder
  import shadow_attr_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       NUM_REGS  = 7,
  parameter logic [7:0]        BASE_OFF  = 8'h59,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 32'h00F0_0000,
  parameter logic [ADDR_W-1:0] HOLE_LAST = 32'h00FF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              host_valid,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_write,
  input  logic              host_code,
  output logic              host_done,
  output logic              host_to_dram,
  output logic              host_cacheable,
  input  logic              pci_valid,
  input  logic [ADDR_W-1:0] pci_addr,
  input  logic              pci_write,
  input  logic              hole_en,
  output logic              pci_done,
  output logic              pci_claim
);

  localparam int unsigned NIBBLES = NUM_REGS * 2;
  localparam int unsigned IDX_W   = $clog2(NIBBLES);
  localparam int unsigned NPORT   = 2;  // 0 = host, 1 = PCI

  logic [NUM_REGS*8-1:0] attr_bits;

  shadow_attr_regs #(.NUM_REGS(NUM_REGS), .BASE_OFF(BASE_OFF)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .attr_bits(attr_bits)
  );

  logic [ADDR_W-1:0] port_addr [NPORT];
  logic              port_win  [NPORT];
  attr_t             port_attr [NPORT];
  logic              unused_low;

  assign port_addr[0] = host_addr;
  assign port_addr[1] = pci_addr;
  assign unused_low   = ^host_addr[13:0];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [IDX_W-1:0] idx;
    shadow_region_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_map (
      .seg_addr(port_addr[p][ADDR_W-1:14]), .in_window(port_win[p]),
      .nib_idx(idx)
    );
    assign port_attr[p] = nib_to_attr(attr_bits[int'(idx)*NIB_W +: NIB_W]);
  end

  logic in_hole, host_dram_d, host_cache_d, pci_claim_d;

  assign in_hole      = (pci_addr >= HOLE_BASE) && (pci_addr <= HOLE_LAST);
  assign host_dram_d  = route_dram(port_win[0], port_attr[0], host_write);
  assign host_cache_d = route_cache(port_win[0], port_attr[0], host_write,
                                    host_code);
  assign pci_claim_d  = !(hole_en && in_hole) &&
                        route_dram(port_win[1], port_attr[1], pci_write);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_done      <= 1'b0;
      host_to_dram   <= 1'b0;
      host_cacheable <= 1'b0;
      pci_done       <= 1'b0;
      pci_claim      <= 1'b0;
    end else begin
      host_done      <= host_valid;
      host_to_dram   <= host_valid && host_dram_d;
      host_cacheable <= host_valid && host_cache_d;
      pci_done       <= pci_valid;
      pci_claim      <= pci_valid && pci_claim_d;
    end
  end

endmodule

// File: rtl/shadow_region_decoder_chk.sv
`timescale 1ns/1ps
module shadow_region_decoder_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [7:0]        BASE_OFF  = 8'h59,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 32'h00F0_0000,
  parameter logic [ADDR_W-1:0] HOLE_LAST = 32'h00FF_FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_addr,
  input logic [7:0]        cfg_rdata,
  input logic              host_valid,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_done,
  input logic              host_to_dram,
  input logic              host_cacheable,
  input logic              pci_valid,
  input logic [ADDR_W-1:0] pci_addr,
  input logic              hole_en,
  input logic              pci_done,
  input logic              pci_claim
);
  logic host_outside, pci_hole;
  assign host_outside = (host_addr < ADDR_W'(32'h000C_0000)) ||
                        (host_addr > ADDR_W'(32'h000F_FFFF));
  assign pci_hole     = hole_en && (pci_addr >= HOLE_BASE) &&
                        (pci_addr <= HOLE_LAST);

  assert_host_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |=> host_done);
  assert_host_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |=> !host_done && !host_to_dram && !host_cacheable);
  assert_pci_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_valid |=> !pci_done && !pci_claim);
  assert_cache_needs_dram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_cacheable |-> host_to_dram);
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[3] && !cfg_rdata[7]);
  assert_base_low_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == BASE_OFF) |-> (cfg_rdata[3:0] == 4'h0));
  assert_hole_unclaimed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_hole |=> !pci_claim);
  assert_outside_dram_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_outside |=> host_to_dram && host_cacheable);
endmodule

bind shadow_region_decoder shadow_region_decoder_chk #(
  .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF), .HOLE_BASE(HOLE_BASE),
  .HOLE_LAST(HOLE_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .host_valid(host_valid), .host_addr(host_addr), .host_done(host_done),
  .host_to_dram(host_to_dram), .host_cacheable(host_cacheable),
  .pci_valid(pci_valid), .pci_addr(pci_addr), .hole_en(hole_en),
  .pci_done(pci_done), .pci_claim(pci_claim)
);

// File: tb/shadow_region_decoder_bench.sv
`timescale 1ns/1ps
module shadow_region_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [7:0] cfg_addr = 0, cfg_wdata = 0; logic [7:0] cfg_rdata;
  logic host_valid = 0, host_write = 0, host_code = 0; logic [31:0] host_addr = 0;
  logic host_done, host_to_dram, host_cacheable;
  logic pci_valid = 0, pci_write = 0, hole_en = 0; logic [31:0] pci_addr = 0;
  logic pci_done, pci_claim;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] mdl [7];

  always #10 clk = ~clk;

  shadow_region_decoder u_shadow_region_decoder (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rsv_mask(input int off);
    if (off == 'h59) return 8'h70;
    if (off > 'h59 && off <= 'h5F) return 8'h77;
    return 8'h00;
  endfunction

  // nibble index of the address, -1 outside the window (R2)
  function automatic int nib_of(input logic [31:0] a);
    if (a < 32'hC0000 || a > 32'hFFFFF) return -1;
    if (a >= 32'hF0000) return 1;
    return 2 + int'((a - 32'hC0000) >> 14);
  endfunction

  function automatic logic [3:0] nib_val(input int n);
    return (n % 2 == 1) ? mdl[n/2][7:4] : mdl[n/2][3:0];
  endfunction

  function automatic bit exp_dram(input logic [31:0] a, input bit wr);
    int n = nib_of(a);
    if (n < 0) return 1;
    return wr ? nib_val(n)[1] : nib_val(n)[0];
  endfunction

  function automatic bit exp_cache(input logic [31:0] a, input bit wr, input bit code);
    int n = nib_of(a);
    logic [3:0] v;
    if (n < 0) return 1;
    v = nib_val(n);
    if (!v[0] || !v[2]) return 0;
    if (v[1]) return 1;
    return !wr && code;
  endfunction

  function automatic bit exp_claim(input logic [31:0] a, input bit wr, input bit he);
    if (he && a >= 32'hF00000 && a <= 32'hFFFFFF) return 0;
    return exp_dram(a, wr);
  endfunction

  function automatic void mdl_write(input int off, input logic [7:0] d);
    if (off >= 'h59 && off <= 'h5F) mdl[off-'h59] = d & rsv_mask(off);
  endfunction

  task automatic cfg_write(input int off, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'(off); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    mdl_write(off, d);
  endtask

  task automatic cfg_check(input int off, input string req);
    logic [7:0] e;
    @(negedge clk);
    cfg_addr = 8'(off);
    #1;
    e = (off >= 'h59 && off <= 'h5F) ? mdl[off-'h59] : 8'h00;
    chk(cfg_rdata == e, req, $sformatf("rdata@%0h", off), cfg_rdata, e);
  endtask

  // one access on each port; optional same-cycle config write
  task automatic access(input logic [31:0] ha, input bit hw, input bit hc,
                        input logic [31:0] pa, input bit pw, input bit he,
                        input bit cw, input int coff, input logic [7:0] cd,
                        input string req);
    bit ed, ec, ep;
    @(negedge clk);
    host_valid = 1; host_addr = ha; host_write = hw; host_code = hc;
    pci_valid = 1; pci_addr = pa; pci_write = pw; hole_en = he;
    cfg_we = cw; cfg_addr = 8'(coff); cfg_wdata = cd;
    ed = exp_dram(ha, hw); ec = exp_cache(ha, hw, hc); ep = exp_claim(pa, pw, he);
    @(negedge clk);
    host_valid = 0; pci_valid = 0; cfg_we = 0;
    if (cw) mdl_write(coff, cd);
    chk(host_done == 1, "R11", "host_done", host_done, 1);
    chk(pci_done == 1, "R11", "pci_done", pci_done, 1);
    chk(host_to_dram == ed, req, $sformatf("to_dram@%0h w%0d", ha, hw), host_to_dram, ed);
    chk(host_cacheable == ec, req, $sformatf("cache@%0h w%0d c%0d", ha, hw, hc), host_cacheable, ec);
    chk(pci_claim == ep, req, $sformatf("claim@%0h w%0d h%0d", pa, pw, he), pci_claim, ep);
  endtask

  task automatic all_dirs(input logic [31:0] a, input string req);
    access(a, 0, 0, a, 0, 0, 0, 0, 0, req);
    access(a, 0, 1, a, 1, 0, 0, 0, 0, req);
    access(a, 1, 0, a, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7781);
    for (int i = 0; i < 7; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int o = 'h57; o <= 'h61; o++) cfg_check(o, "R1");
    all_dirs(32'hC4000, "R1");
    access(32'hF8000, 1, 0, 32'hF8000, 1, 0, 0, 0, 0, "R1");
    // R10 outside the window
    access(32'h0001_0000, 0, 0, 32'h0010_0000, 1, 0, 0, 0, 0, "R10");
    access(32'h000B_FFFF, 1, 0, 32'h000B_FFFF, 0, 0, 0, 0, 0, "R10");
    // R3 reserved bits and unmapped offsets
    cfg_write('h59, 8'hFF); cfg_check('h59, "R3");
    cfg_write('h5C, 8'hFF); cfg_check('h5C, "R3");
    cfg_write('h60, 8'hFF); cfg_check('h60, "R3");
    cfg_write('h58, 8'hFF); cfg_check('h58, "R3");
    all_dirs(32'hF0000, "R3");
    // R4..R7 attribute codes on region 0C0000h
    cfg_write('h5A, 8'h00); all_dirs(32'hC0000, "R4");
    cfg_write('h5A, 8'h01); all_dirs(32'hC1000, "R5");
    cfg_write('h5A, 8'h05); all_dirs(32'hC3FFF, "R5");
    cfg_write('h5A, 8'h02); all_dirs(32'hC2000, "R6");
    cfg_write('h5A, 8'h06); all_dirs(32'hC2000, "R6");
    cfg_write('h5A, 8'h03); all_dirs(32'hC0010, "R7");
    cfg_write('h5A, 8'h07); all_dirs(32'hC0010, "R7");
    // R2 region map: each nibble alone, probe region edges
    for (int n = 1; n < 14; n++) begin
      for (int o = 'h59; o <= 'h5F; o++) cfg_write(o, 8'h00);
      cfg_write('h59 + n/2, (n % 2) ? 8'h30 : 8'h03);
      all_dirs(n == 1 ? 32'hF0000 : 32'hC0000 + (n-2)*32'h4000, "R2");
      access(n == 1 ? 32'hFFFFF : 32'hC3FFF + (n-2)*32'h4000, 0, 0,
             n == 1 ? 32'hEFFFF : 32'hC4000 + (n-2)*32'h4000, 0, 0, 0, 0, 0, "R2");
    end
    // R8 per-direction PCI claim
    cfg_write('h5E, 8'h21);
    access(32'h0, 0, 0, 32'hE0000, 0, 0, 0, 0, 0, "R8");
    access(32'h0, 0, 0, 32'hE0000, 1, 0, 0, 0, 0, "R8");
    access(32'h0, 0, 0, 32'hE4000, 1, 0, 0, 0, 0, "R8");
    access(32'h0, 0, 0, 32'hE4000, 0, 0, 0, 0, 0, "R8");
    // R9 memory hole
    access(32'h0, 0, 0, 32'hF00010, 0, 1, 0, 0, 0, "R9");
    access(32'h0, 0, 0, 32'hFFFFFF, 1, 1, 0, 0, 0, "R9");
    access(32'h0, 0, 0, 32'hF00010, 0, 0, 0, 0, 0, "R9");
    access(32'h0, 0, 0, 32'hEFFFFF, 1, 1, 0, 0, 0, "R9");
    // R11 same-cycle config write sees old attributes
    cfg_write('h5B, 8'h00);
    access(32'hC8000, 0, 0, 32'hC8000, 0, 0, 1, 'h5B, 8'h07, "R11");
    access(32'hC8000, 0, 0, 32'hC8000, 0, 0, 1, 'h5B, 8'h00, "R11");
    access(32'hC8000, 0, 0, 32'hC8000, 0, 0, 0, 0, 0, "R11");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ha, pa;
      ha = ($urandom % 4 != 0) ? 32'hC0000 + ($urandom % 32'h40000) : $urandom % 32'h0200_0000;
      pa = ($urandom % 4 == 0) ? 32'hF00000 + ($urandom % 32'h100000)
         : 32'hC0000 + ($urandom % 32'h40000);
      if ($urandom % 5 == 0) cfg_write('h58 + ($urandom % 9), 8'($urandom));
      access(ha, 1'($urandom), 1'($urandom), pa, 1'($urandom), 1'($urandom),
             ($urandom % 6 == 0), 'h59 + ($urandom % 7), 8'($urandom), "R7");
      if (i % 50 == 0) cfg_check('h59 + ($urandom % 7), "R3");
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule